// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This peripheral holds a 32-bit time base that counts up by one on every clock and can be reloaded by software. Five compare channels watch the top five bits of that count. Each channel has a compare value and a don't-care mask. When the count matches, the channel drives its programmed output level on its pin. When the count does not match, the channel drives the opposite level. On a new match, a channel can also latch an interrupt status bit, and each status bit is gated by a per-channel mask onto its own interrupt line.

Software reaches the block over a plain 32-bit register port, and every access must be full-word. The read path is combinational. Per-channel output fields occupy bits 31:27, and per-channel interrupt fields occupy bits 15:11. Interrupt status has one address where written ones set bits and another where written ones clear them.

Top module: `cmp_timer_top`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads zero, the count is zero, and both `chan_out` and `chan_irq` are all zero.
- R2: The count rises by one on each clock and wraps from 0xFFFFFFFF to 0. A word write to offset 0x00 loads the written value, and a read of 0x00 returns the current count.
- R3: Output enable (0x10), output level (0x14), compare value n (0x80+4n) and compare mask n (0xC0+4n) keep only bits 31:27, with channel n at bit 31-n. All other bits read as zero.
- R4: Interrupt mask (0x18) and interrupt enable (0x24) keep only bits 15:11, with channel n at bit 15-n. All other bits read as zero.
- R5: A write to 0x1C ORs data bits 15:11 into status. A write to 0x20 clears the status bits written as one. A read of either address returns the status.
- R6: Channel n matches when ((count[31:27] XOR compare_n) AND NOT mask_n) is zero. A mask bit of one removes that bit from the comparison.
- R7: `chan_out[n]` is 0 while its enable bit is 0. While the enable bit is 1, `chan_out[n]` equals the level bit on a match and the inverse of the level bit otherwise.
- R8: `chan_irq[n]` is 1 exactly when both the status bit and the mask bit of channel n are 1.
- R9: On the clock after channel n goes from no match to match, the status bit of channel n is set, but only if its interrupt-enable bit is 1. A match that simply persists sets nothing. A clear write in that same cycle loses to the hardware set.
- R10: An access whose size code is not 2'b10 raises `bus_err` during that cycle, returns 0xFFFFFFFF, and changes no register. A word read of an unmapped or misaligned offset returns 0xFFFFFFFF with `bus_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code, 2'b10 = 32-bit word |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Access rejected for size |
| chan_out | output | 5 | Channel output pins, bit n = channel n |
| chan_irq | output | 5 | Channel interrupt lines, bit n = channel n |

## Verification
The bench sweeps all 32 values of the counter's top field against several compare, mask, level and enable settings, and predicts every output pin arithmetically. An inverted polarity, a mask applied to the wrong operand, or reversed channel bit order therefore shows up at once. It also checks the separate bit placements of the two field families, so a design that packed interrupt bits at 31:27 would read back wrong values. The hardware status set is checked in three cases: with enable off, under a persisting match (where a level-sensitive design would re-set the bit after a clear), and with a clear write in the same cycle as the edge (where the wrong priority drops the event). Rejected sizes are checked for both error signalling and the absence of any register change.

// File: rtl/ct_pkg.sv
// Shared constants, types and bit-placement helpers for the compare timer.
// Assumes the channel count does not exceed the compare field width.
package ct_pkg;
    localparam int NCH      = 5;
    localparam int CW       = 32;
    localparam int FW       = 5;
    localparam int AW       = 8;
    localparam int FLD_LSB  = CW - FW;
    localparam int IRQ_MSB  = 15;
    localparam int CIW      = $clog2(NCH);
    localparam int STRIDE   = 4;

    localparam logic [1:0]    SZ_WORD  = 2'b10;
    localparam logic [AW-1:0] A_TB     = 8'h00;
    localparam logic [AW-1:0] A_OE     = 8'h10;
    localparam logic [AW-1:0] A_LVL    = 8'h14;
    localparam logic [AW-1:0] A_MSK    = 8'h18;
    localparam logic [AW-1:0] A_SET    = 8'h1C;
    localparam logic [AW-1:0] A_CLR    = 8'h20;
    localparam logic [AW-1:0] A_EN     = 8'h24;
    localparam logic [AW-1:0] A_CMP    = 8'h80;
    localparam logic [AW-1:0] A_CMK    = 8'hC0;
    localparam logic [AW-1:0] SPAN     = AW'(STRIDE * (NCH - 1));

    typedef logic [NCH-1:0] chvec_t;
    typedef logic [FW-1:0]  fld_t;

    // Channel n taken from word bit CW-1-n
    function automatic chvec_t hi_get(logic [CW-1:0] w);
        chvec_t r;
        for (int n = 0; n < NCH; n++) r[n] = w[CW-1-n];
        return r;
    endfunction

    // Channel n placed at word bit CW-1-n
    function automatic logic [CW-1:0] hi_put(chvec_t v);
        logic [CW-1:0] r;
        r = '0;
        for (int n = 0; n < NCH; n++) r[CW-1-n] = v[n];
        return r;
    endfunction

    // Channel n taken from word bit IRQ_MSB-n
    function automatic chvec_t lo_get(logic [CW-1:0] w);
        chvec_t r;
        for (int n = 0; n < NCH; n++) r[n] = w[IRQ_MSB-n];
        return r;
    endfunction

    // Channel n placed at word bit IRQ_MSB-n
    function automatic logic [CW-1:0] lo_put(chvec_t v);
        logic [CW-1:0] r;
        r = '0;
        for (int n = 0; n < NCH; n++) r[IRQ_MSB-n] = v[n];
        return r;
    endfunction
endpackage

// File: rtl/ct_timebase.sv
// Free-running up counter with a software load.
// Assumes the load strobe is already qualified as a valid word write.
module ct_timebase
    import ct_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt
);
    // Count up each clock, or take the loaded value
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (ld) cnt <= ld_val;
        else         cnt <= cnt + CW'(1);
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/ct_chan.sv
// One compare channel: masked match against the top count field, output
// level selection and rising-edge detection for the status set.
// Assumes all configuration inputs come from registers.
module ct_chan
    import ct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  fld_t cnt_top,
    input  fld_t cmp,
    input  fld_t cmk,
    input  logic oe,
    input  logic lvl,
    input  logic en,
    output logic out,
    output logic hw_set
);
    logic match;
    logic match_q;

    // Masked equality of the counter field against the compare value
    always_comb match = ((cnt_top ^ cmp) & ~cmk) == '0;

    // Pin level: programmed level on match, inverse otherwise, 0 if disabled
    always_comb out = oe & (match ? lvl : ~lvl);

    // Remember the previous match for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    // Request a status set on a new match when enabled
    always_comb hw_set = match & ~match_q & en;

    // R9
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> !hw_set);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cnt_top) && $stable(cmp) && $stable(cmk) && $stable(oe) && $stable(lvl))
        |-> $stable(out));
endmodule

// File: rtl/ct_regfile.sv
// Register port decode, configuration and status storage and read mux.
// Assumes the read data is consumed in the same cycle as the request.
module ct_regfile
    import ct_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel,
    input  logic                   wr,
    input  logic [1:0]             size,
    input  logic [AW-1:0]          addr,
    input  logic [CW-1:0]          wdata,
    input  logic [CW-1:0]          count,
    input  chvec_t                 hw_set,
    output logic [CW-1:0]          rdata,
    output logic                   err,
    output logic                   ld,
    output logic [CW-1:0]          ld_val,
    output chvec_t                 oe_q,
    output chvec_t                 lvl_q,
    output chvec_t                 msk_q,
    output chvec_t                 en_q,
    output chvec_t                 sts_q,
    output logic [NCH-1:0][FW-1:0] cmp_q,
    output logic [NCH-1:0][FW-1:0] cmk_q
);
    logic           ok, wok;
    logic           cmp_hit, cmk_hit;
    logic [AW-1:0]  coff, koff;
    logic [CIW-1:0] cidx, kidx;
    chvec_t         set_v, clr_v, sts_d;

    // Qualify the access and locate compare-array hits
    always_comb begin
        ok      = sel && (size == SZ_WORD);
        err     = sel && (size != SZ_WORD);
        wok     = ok && wr;
        coff    = addr - A_CMP;
        koff    = addr - A_CMK;
        cidx    = coff[CIW+1:2];
        kidx    = koff[CIW+1:2];
        cmp_hit = (addr >= A_CMP) && (addr <= A_CMP + SPAN) && (addr[1:0] == 2'b00);
        cmk_hit = (addr >= A_CMK) && (addr <= A_CMK + SPAN) && (addr[1:0] == 2'b00);
        ld      = wok && (addr == A_TB);
        ld_val  = wdata;
    end

    // Next status: software set, then software clear, then hardware set wins
    always_comb begin
        set_v = (wok && addr == A_SET) ? lo_get(wdata) : '0;
        clr_v = (wok && addr == A_CLR) ? lo_get(wdata) : '0;
        sts_d = ((sts_q | set_v) & ~clr_v) | hw_set;
    end

    // Configuration registers, written on qualified word writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= '0;
            lvl_q <= '0;
            msk_q <= '0;
            en_q  <= '0;
            cmp_q <= '0;
            cmk_q <= '0;
        end else if (wok) begin
            if (addr == A_OE)  oe_q  <= hi_get(wdata);
            if (addr == A_LVL) lvl_q <= hi_get(wdata);
            if (addr == A_MSK) msk_q <= lo_get(wdata);
            if (addr == A_EN)  en_q  <= lo_get(wdata);
            if (cmp_hit)       cmp_q[cidx] <= wdata[CW-1:FLD_LSB];
            if (cmk_hit)       cmk_q[kidx] <= wdata[CW-1:FLD_LSB];
        end
    end

    // Interrupt status register
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    // Read mux; rejected or unmapped reads give all ones
    always_comb begin
        rdata = '1;
        if (ok) begin
            if (cmp_hit)
                rdata = {cmp_q[cidx], {FLD_LSB{1'b0}}};
            else if (cmk_hit)
                rdata = {cmk_q[kidx], {FLD_LSB{1'b0}}};
            else begin
                case (addr)
                    A_TB:         rdata = count;
                    A_OE:         rdata = hi_put(oe_q);
                    A_LVL:        rdata = hi_put(lvl_q);
                    A_MSK:        rdata = lo_put(msk_q);
                    A_SET, A_CLR: rdata = lo_put(sts_q);
                    A_EN:         rdata = lo_put(en_q);
                    default:      rdata = '1;
                endcase
            end
        end
    end

    // R10
    bad_size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && size != SZ_WORD)
        |=> ($stable(oe_q) && $stable(lvl_q) && $stable(msk_q) && $stable(en_q)));

    for (genvar n = 0; n < NCH; n++) begin : g_sts_chk
        // R5
        sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[n] && !hw_set[n]) |=> !sts_q[n]);
        // R9
        sts_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_q[n]) |-> ($past(hw_set[n]) || $past(set_v[n])));
    end
endmodule

// File: rtl/cmp_timer_top.sv
// Five-channel compare timer: time base, per-channel compare logic and a
// word-wide register port. Assumes a single clock domain for all inputs.
module cmp_timer_top (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_size,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    output logic [4:0]  chan_out,
    output logic [4:0]  chan_irq
);
    import ct_pkg::*;

    logic                   ld;
    logic [CW-1:0]          ld_val, cnt;
    chvec_t                 oe_q, lvl_q, msk_q, en_q, sts_q, hw_set, outs;
    logic [NCH-1:0][FW-1:0] cmp_q, cmk_q;

    ct_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .size(bus_size),
        .addr(bus_addr), .wdata(bus_wdata), .count(cnt), .hw_set(hw_set),
        .rdata(bus_rdata), .err(bus_err), .ld(ld), .ld_val(ld_val),
        .oe_q(oe_q), .lvl_q(lvl_q), .msk_q(msk_q), .en_q(en_q), .sts_q(sts_q),
        .cmp_q(cmp_q), .cmk_q(cmk_q)
    );

    ct_timebase u_tb (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .cnt(cnt)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        ct_chan u_ch (
            .clk(clk), .rst_n(rst_n), .cnt_top(cnt[CW-1:FLD_LSB]),
            .cmp(cmp_q[n]), .cmk(cmk_q[n]), .oe(oe_q[n]), .lvl(lvl_q[n]),
            .en(en_q[n]), .out(outs[n]), .hw_set(hw_set[n])
        );
    end

    // Drive pins and gate status onto the interrupt lines
    always_comb begin
        chan_out = outs;
        chan_irq = sts_q & msk_q;
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sts_q) && $stable(msk_q)) |-> $stable(chan_irq));
endmodule

// File: tb/tb_cmp_timer_top.sv
module tb_cmp_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [4:0]  chan_out, chan_irq;

    int total = 0;
    int bad = 0;
    logic [31:0] d;
    logic        e;

    always #5 clk = ~clk;

    cmp_timer_top dut (.*);

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v, logic [1:0] sz = 2'b10);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v; bus_size = sz;
        #1 e = bus_err;
        @(posedge clk);
        #1 bus_sel = 0; bus_wr = 0; bus_size = 2'b10;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] q, output logic qe,
                      input logic [1:0] sz = 2'b10);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
        #1 q = bus_rdata; qe = bus_err;
        @(posedge clk);
        #1 bus_sel = 0; bus_size = 2'b10;
    endtask

    function automatic logic [31:0] hp(logic [4:0] v);
        logic [31:0] r = '0;
        for (int n = 0; n < 5; n++) r[31-n] = v[n];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=done");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        @(negedge clk); #1;
        chk("R1 out", {27'b0, chan_out}, 0);
        chk("R1 irq", {27'b0, chan_irq}, 0);
        foreach (d[i]) if (0) d = 0;
        begin
            logic [7:0] regs [6] = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
            foreach (regs[i]) begin rd(regs[i], d, e); chk("R1 reg", d, 0); end
        end
        for (int n = 0; n < 5; n++) begin
            rd(8'(8'h80 + 4*n), d, e); chk("R1 cmp", d, 0);
            rd(8'(8'hC0 + 4*n), d, e); chk("R1 cmk", d, 0);
        end

        // R3 / R4: field placement
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d, e); chk("R3 oe", d, 32'hF800_0000);
        wr(8'h14, 32'h4321_FFFF); rd(8'h14, d, e); chk("R3 lvl", d, 32'h4000_0000);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d, e); chk("R4 msk", d, 32'h0000_F800);
        wr(8'h24, 32'h0000_4FFF); rd(8'h24, d, e); chk("R4 en", d, 32'h0000_4800);
        for (int n = 0; n < 5; n++) begin
            wr(8'(8'h80 + 4*n), (32'h8000_0000 >> n) | 32'h0000_1234);
            wr(8'(8'hC0 + 4*n), (32'h0800_0000 << n) | 32'h0012_0000);
        end
        for (int n = 0; n < 5; n++) begin
            rd(8'(8'h80 + 4*n), d, e); chk("R3 cmp", d, 32'h8000_0000 >> n);
            rd(8'(8'hC0 + 4*n), d, e); chk("R3 cmk", d, 32'h0800_0000 << n);
        end
        wr(8'h10, 0); wr(8'h14, 0); wr(8'h18, 0); wr(8'h24, 0);

        // R2: load, count and wrap
        wr(8'h00, 32'h1234_5678);
        rd(8'h00, d, e); chk("R2 load", d, 32'h1234_5678);
        rd(8'h00, d, e); chk("R2 step", d, 32'h1234_5679);
        rd(8'h00, d, e); chk("R2 step2", d, 32'h1234_567A);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d, e); chk("R2 top", d, 32'hFFFF_FFFF);
        rd(8'h00, d, e); chk("R2 wrap", d, 32'h0000_0000);

        // R10: rejected sizes and unmapped offsets
        wr(8'h10, 32'hFFFF_FFFF, 2'b01); chk("R10 werr", {31'b0, e}, 1);
        rd(8'h10, d, e); chk("R10 nochange", d, 0);
        rd(8'h10, d, e, 2'b00); chk("R10 rdata", d, 32'hFFFF_FFFF);
        chk("R10 rerr", {31'b0, e}, 1);
        rd(8'h40, d, e); chk("R10 unmapped", d, 32'hFFFF_FFFF);
        chk("R10 noerr", {31'b0, e}, 0);
        rd(8'h82, d, e); chk("R10 misalign", d, 32'hFFFF_FFFF);
        rd(8'h94, d, e); chk("R10 past cmp", d, 32'hFFFF_FFFF);

        // R5: set/clear status
        wr(8'h1C, 32'hFFFF_A8FF);
        rd(8'h1C, d, e); chk("R5 set", d, 32'h0000_A800);
        rd(8'h20, d, e); chk("R5 alias", d, 32'h0000_A800);
        wr(8'h1C, 32'h0000_1000);
        wr(8'h20, 32'h0000_2000);
        rd(8'h1C, d, e); chk("R5 clr", d, 32'h0000_9800);

        // R8: interrupt gating
        wr(8'h18, 32'h0000_F800);
        @(negedge clk); #1 chk("R8 all", {27'b0, chan_irq}, 32'h19);
        wr(8'h18, 32'h0000_4000);
        @(negedge clk); #1 chk("R8 ch1 off", {27'b0, chan_irq}, 0);
        wr(8'h18, 32'h0000_0800);
        @(negedge clk); #1 chk("R8 ch4", {27'b0, chan_irq}, 32'h10);
        wr(8'h20, 32'hFFFF_FFFF);
        @(negedge clk); #1 chk("R8 cleared", {27'b0, chan_irq}, 0);
        wr(8'h18, 0);

        // R6 / R7: sweep counter top field against several setups
        for (int r = 0; r < 6; r++) begin
            logic [4:0] c [5];
            logic [4:0] k [5];
            logic [4:0] lv, oev, exp;
            lv  = 5'((r * 13 + 3) % 32);
            oev = (r == 4) ? 5'b00101 : 5'b11111;
            for (int n = 0; n < 5; n++) begin
                c[n] = 5'((r * 7 + n * 11) % 32);
                k[n] = (r % 2 == 1) ? 5'((r * 9 + n * 5) % 32) : 5'd0;
                wr(8'(8'h80 + 4*n), {c[n], 27'h0ABCDEF});
                wr(8'(8'hC0 + 4*n), {k[n], 27'h0});
            end
            wr(8'h10, hp(oev));
            wr(8'h14, hp(lv));
            for (int t = 0; t < 32; t++) begin
                wr(8'h00, {5'(t), 27'h0});
                for (int n = 0; n < 5; n++) begin
                    logic m;
                    m = (((5'(t) ^ c[n]) & ~k[n]) == 5'd0);
                    exp[n] = oev[n] & (m ? lv[n] : ~lv[n]);
                end
                @(negedge clk); #1 chk("R6 R7 sweep", {27'b0, chan_out}, {27'b0, exp});
            end
        end

        // R9: hardware set on a new match
        wr(8'h10, 0); wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h80, 32'h1800_0000); wr(8'hC0, 0);
        wr(8'h84, 32'h1800_0000); wr(8'hC4, 0);
        for (int n = 2; n < 5; n++) wr(8'(8'h80 + 4*n), 32'hF800_0000);
        wr(8'h24, 32'h0000_8000);
        wr(8'h18, 32'h0000_8000);
        wr(8'h00, 32'h0000_0000); @(negedge clk);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h00, 32'h1800_0000); @(negedge clk);
        rd(8'h1C, d, e); chk("R9 set enabled only", d, 32'h0000_8000);
        @(negedge clk); #1 chk("R9 irq", {27'b0, chan_irq}, 1);
        wr(8'h20, 32'h0000_8000); @(negedge clk);
        rd(8'h1C, d, e); chk("R9 no reset on held match", d, 0);
        wr(8'h00, 32'h0000_0000); @(negedge clk);
        wr(8'h00, 32'h1800_0000);
        wr(8'h20, 32'h0000_8000);
        rd(8'h1C, d, e); chk("R9 set beats clear", d, 32'h0000_8000);

        report();
    end
endmodule